// File: doc/BRIEF.md
# Memory-Backed Pattern Sequencer

This block holds a sixteen-entry table of 4-bit words and replays it in address order, so it can serve as a pattern source for a row of LEDs or as a coarse waveform source for a digital-to-analog converter. A single mode input picks the address source. In load mode the table is addressed by a manual address input, and a write strobe stores a word there. In play mode an internal step counter walks all sixteen addresses at a programmable rate. That rate can be slow enough for a person to follow by eye.

The step rate comes from a clock-enable divider clocked by the system clock. The divider has a programmable terminal count, so no derived clock is used. The output is the current table word. The same word is also given as an 8-bit converter code: the word sits in the upper nibble and the lower nibble is zero.

Top module: `pattern_seq_top`

## Requirements
- R1: While the synchronous active-low reset is held, every table entry and the output word are cleared to zero. After reset, `word_out` and `dac_code` read zero.
- R2: In load mode (`play_mode` = 0), a clock edge with `wr_strobe` = 1 stores `wr_data` at the entry selected by `man_addr`.
- R3: In play mode (`play_mode` = 1), `wr_strobe` has no effect on the table contents.
- R4: In load mode, `word_out` shows the entry at `man_addr` one clock edge after that address is presented.
- R5: On entry to play mode, the step counter starts at address 0. `word_out` shows entry 0 after the first play-mode clock edge.
- R6: In play mode, the step counter advances once every `rate_tc`+1 clock edges. `word_out` changes one edge after each advance and holds steady in between. With `rate_tc` = 0 the counter advances on every edge.
- R7: The step counter wraps from address 15 to address 0 and continues.
- R8: In play mode, `man_addr` has no effect on the output. In load mode, the step counter is held at 0.
- R9: `dac_code` bits 7:4 always equal `word_out`, and `dac_code` bits 3:0 are always zero.
- R10: If play mode is left for even one clock edge and then entered again, playback restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| play_mode | input | 1 | Mode select: 0 = load (manual address), 1 = play (step counter) |
| man_addr | input | 4 | Manual table address, used in load mode |
| wr_data | input | 4 | Word to store in load mode |
| wr_strobe | input | 1 | Write request; honoured only in load mode |
| rate_tc | input | 24 | Divider terminal count; the step period is rate_tc+1 clocks |
| word_out | output | 4 | Current table word, for LED display |
| dac_code | output | 8 | Converter code: the word in bits 7:4, zeros in bits 3:0 |

## Verification
The checker watches the step counter and the divider tick on every cycle. On each cycle it confirms that the counter is zero on play entry and held at zero in load mode, that it does not move between ticks, that it wraps from 15 to 0, and that the converter code carries the word with a zero low nibble.

Some behaviour needs stored data to observe, so only the bench's scenarios can show it. That includes writes landing at the right entry, strobes being ignored in play mode, the manual address being ignored during playback, the exact per-edge playback word at two different rates, and the restart after a brief return to load mode.

// File: rtl/pseq_pkg.sv
// Shared types for the pattern sequencer.
package pseq_pkg;
    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_PLAY = 1'b1
    } pseq_mode_e;
endpackage

// File: rtl/pseq_rate_gen.sv
// Clock-enable divider: raises tick for one clock every rate_tc+1 clocks while
// run is high. Assumes rate_tc is held steady during playback; a smaller value
// written mid-count takes effect at once because the compare is >=.
module pseq_rate_gen #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] rate_tc,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= rate_tc);

    // Count up while running; restart after each tick and whenever stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pseq_step_ctr.sv
// Playback address counter. Held at zero while not running, so it always
// starts from zero on play entry. Advances on step and wraps naturally.
module pseq_step_ctr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step,
    output logic [ADDR_W-1:0] idx
);
    // Clear on reset or outside play, otherwise advance on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) idx <= '0;
        else if (step)      idx <= idx + 1'b1;
    end
endmodule

// File: rtl/pseq_store.sv
// Small register-file table with one write port and one registered read port.
// Reads return the contents from before a same-edge write. All rows clear on
// reset.
module pseq_store #(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] rows [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic [DATA_W-1:0] row_q;
        // Capture write data when this row is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                            row_q <= '0;
            else if (we && waddr == ADDR_W'(g))    row_q <= wdata;
        end
        assign rows[g] = row_q;
    end

    // Register the selected row as the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rows[raddr];
    end
endmodule

// File: rtl/pattern_seq_top.sv
// Memory-backed pattern sequencer. In load mode the manual address selects the
// table entry and the strobe writes. In play mode a divided step counter walks
// the table. Outputs are the registered word and a converter code with that
// word left-justified.
module pattern_seq_top #(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 24,
    parameter int DAC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              play_mode,
    input  logic [ADDR_W-1:0] man_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_strobe,
    input  logic [DIV_W-1:0]  rate_tc,
    output logic [DATA_W-1:0] word_out,
    output logic [DAC_W-1:0]  dac_code
);
    import pseq_pkg::*;

    localparam int PAD_W = (DAC_W > DATA_W) ? DAC_W - DATA_W : 1;

    pseq_mode_e        mode;
    logic              run;
    logic              step_tick;
    logic [ADDR_W-1:0] step_idx;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;

    assign mode    = pseq_mode_e'(play_mode);
    assign run     = (mode == MODE_PLAY);
    assign rd_addr = run ? step_idx : man_addr;
    assign wr_en   = wr_strobe && (mode == MODE_LOAD);

    pseq_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .rate_tc (rate_tc),
        .tick    (step_tick)
    );

    pseq_step_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (step_tick),
        .idx   (step_idx)
    );

    pseq_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (man_addr),
        .wdata   (wr_data),
        .raddr   (rd_addr),
        .rdata_q (word_out)
    );

    if (DAC_W > DATA_W) begin : g_dac_pad
        logic [PAD_W-1:0] pad;
        assign pad      = '0;
        assign dac_code = {word_out, pad};
    end else begin : g_dac_trunc
        assign dac_code = word_out[DATA_W-1 -: DAC_W];
    end
endmodule

// File: rtl/pseq_checker.sv
// Cycle-level properties of the pattern sequencer, bound to the top module.
module pseq_checker #(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 4,
    parameter int DAC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              play_mode,
    input logic              step_tick,
    input logic [ADDR_W-1:0] step_idx,
    input logic [DATA_W-1:0] word_out,
    input logic [DAC_W-1:0]  dac_code
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    // R5: counter is at address zero on the first play cycle
    assert_play_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(play_mode) |-> step_idx == '0);

    // R8: counter held at zero during load mode
    assert_load_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !play_mode |=> step_idx == '0);

    // R6: no movement between divider ticks
    assert_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (play_mode && !step_tick) |=> $stable(step_idx));

    // R6: a tick advances by exactly one
    assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (play_mode && step_tick && step_idx != LAST) |=> step_idx == $past(step_idx) + 1'b1);

    // R7: wrap from last address to zero
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (play_mode && step_tick && step_idx == LAST) |=> step_idx == '0);

    // R9: converter code carries the word over a zero low part
    assert_dac_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dac_code == {word_out, {(DAC_W-DATA_W){1'b0}}});
endmodule

bind pattern_seq_top pseq_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DAC_W(DAC_W)
) u_pseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .play_mode (play_mode),
    .step_tick (step_tick),
    .step_idx  (step_idx),
    .word_out  (word_out),
    .dac_code  (dac_code)
);

// File: tb/pattern_seq_top_bench.sv
`timescale 1ns/1ps
module pattern_seq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        play_mode = 1'b0;
    logic [3:0]  man_addr = '0;
    logic [3:0]  wr_data = '0;
    logic        wr_strobe = 1'b0;
    logic [23:0] rate_tc = '0;
    logic [3:0]  word_out;
    logic [7:0]  dac_code;

    int n_checks = 0;
    int n_fails  = 0;
    logic [3:0] ref_mem [16];

    always #2.5 clk = ~clk;

    pattern_seq_top u_pattern_seq_top (
        .clk(clk), .rst_n(rst_n), .play_mode(play_mode), .man_addr(man_addr),
        .wr_data(wr_data), .wr_strobe(wr_strobe), .rate_tc(rate_tc),
        .word_out(word_out), .dac_code(dac_code)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    task automatic write_word(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        man_addr = a; wr_data = d; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [3:0] a, input logic [3:0] expv);
        @(negedge clk);
        man_addr = a;
        @(posedge clk);
        @(negedge clk);
        check(req, {4'h0, word_out}, {4'h0, expv});
        check("R9", dac_code, {expv, 4'h0});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {4'h0, word_out}, 8'h00);
        check("R1", dac_code, 8'h00);
        read_check("R1", 4'd9, 4'h0);
        read_check("R1", 4'd15, 4'h0);
    endtask

    task automatic t_load();
        for (int i = 0; i < 16; i++) begin
            ref_mem[i] = 4'((i * 7 + 3) & 15);
            write_word(4'(i), ref_mem[i]);
        end
        read_check("R2", 4'd0, ref_mem[0]);
        read_check("R4", 4'd12, ref_mem[12]);
        read_check("R4", 4'd5, ref_mem[5]);
        ref_mem[0] = 4'hE;
        write_word(4'd0, 4'hE);
        read_check("R2", 4'd0, 4'hE);
        read_check("R4", 4'd15, ref_mem[15]);
    endtask

    // Play for the given number of edges, with manual address churn (R8) and a
    // stray write strobe (R3) along the way.
    task automatic t_play(input int tc, input int edges);
        @(negedge clk);
        rate_tc = 24'(tc);
        play_mode = 1'b1;
        for (int n = 0; n < edges; n++) begin
            @(posedge clk);
            @(negedge clk);
            check((n == 0) ? "R5" : ((n / (tc + 1)) >= 16 ? "R7" : "R6"),
                  {4'h0, word_out}, {4'h0, ref_mem[(n / (tc + 1)) % 16]});
            man_addr = 4'((n * 5 + 1) & 15);
            if (n == 4) begin
                man_addr = 4'd5; wr_data = ~ref_mem[5]; wr_strobe = 1'b1;
            end
            if (n == 5) wr_strobe = 1'b0;
        end
        wr_strobe = 1'b0;
        play_mode = 1'b0;
        @(posedge clk);
    endtask

    task automatic t_write_ignored();
        read_check("R3", 4'd5, ref_mem[5]);
        read_check("R8", 4'd1, ref_mem[1]);
    endtask

    task automatic t_restart();
        @(negedge clk);
        rate_tc = 24'd1;
        play_mode = 1'b1;
        repeat (9) @(negedge clk);
        play_mode = 1'b0;
        @(negedge clk);
        play_mode = 1'b1;
        for (int n = 0; n < 6; n++) begin
            @(posedge clk);
            @(negedge clk);
            check("R10", {4'h0, word_out}, {4'h0, ref_mem[(n / 2) % 16]});
        end
        play_mode = 1'b0;
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_load();
        t_play(2, 16 * 3 + 8);
        t_write_ignored();
        t_play(0, 20);
        t_restart();
        summary();
    end
endmodule